// File: doc/BRIEF.md
# Multicast hash address filter

This block sits at the front of a receive path and decides, from the destination address at the head of a frame, whether the frame is kept. The six address bytes arrive one per strobe, first byte first. While they arrive the block runs a bit-reflected CRC-32 over them and compares them against the station address. When the closing strobe arrives it gives a single keep/drop verdict.

An address whose first byte has its least significant bit set is a group (multicast) address. For such an address the top six bits of the CRC form a hash, and that hash picks one bit of a 64-bit filter table supplied as four 16-bit words. Any other address is an individual (unicast) address, and it is kept only when it equals the station address exactly. A promiscuous input overrides both rules and keeps every frame. Software builds the filter table elsewhere. The frame check sequence of the frame is also checked elsewhere.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `result_valid` and `accept` are both 0.
- R2: The hash is bits [31:26] of a CRC register. The register is preset to 0xFFFFFFFF and updated with the reflected polynomial 0xEDB88320. Each byte is fed least significant bit first, and no final inversion is applied.
- R3: When the first address byte has bit 0 equal to 1, the frame is accepted exactly when filter bit `filt_words[16*hash[5:4] + hash[3:0]]` is 1. Word w of the table occupies `filt_words[16*w+15:16*w]`.
- R4: With all 64 filter bits set, every multicast address is accepted, the all-ones broadcast address included.
- R5: When the first address byte has bit 0 equal to 0, the frame is accepted only if all 48 bits equal `station_addr`. The first byte received is compared with `station_addr[7:0]`, and byte k with `station_addr[8k+7:8k]`. The filter table has no effect on such frames.
- R6: With `promisc` = 1 at the closing strobe, the frame is accepted whatever its address and length.
- R7: `result_valid` is 1 in the cycle after the edge that takes the byte carrying `byte_last`. It and `accept` then hold unchanged, even if `promisc`, `filt_words` or `station_addr` change, until the next valid byte.
- R8: The first valid byte of a new frame clears `result_valid` and `accept` on its edge. The CRC and the comparison restart with that byte, so frames may follow each other with no idle cycle.
- R9: A frame whose closing strobe falls on any byte other than the sixth is rejected unless `promisc` is 1.
- R10: Idle cycles (`byte_valid` = 0) between address bytes change neither the hash, the comparison nor the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | An address byte is present on `byte_data` |
| byte_data | input | 8 | Address byte, first byte of the address first |
| byte_last | input | 1 | Marks the closing byte of the address |
| filt_words | input | 64 | Four 16-bit filter words, word w at [16w+15:16w] |
| station_addr | input | 48 | Station address, first byte at [7:0] |
| promisc | input | 1 | Keep every frame |
| result_valid | output | 1 | Verdict is present |
| accept | output | 1 | Verdict: 1 keeps the frame |

## Verification
The bench drives 64 group addresses. For each one it sets only the filter bit that its hash selects, then every bit except that one. A design with a wrong bit order, preset, word select or hash slice therefore accepts or rejects the wrong frame. Each of the 48 station-address bits is flipped once, which exposes a comparison that skips a byte or a bit. Flipping bit 0 turns the address into a group address, which exposes a design that uses the filter table for individual addresses. Five-byte and seven-byte frames, frames with idle gaps, back-to-back frames and changes to inputs while a verdict is held expose a length check that is off by one, a CRC that advances without a valid byte, a verdict that is not cleared, and a verdict that tracks live inputs.

// File: rtl/afilt_pkg.sv
package afilt_pkg;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_BUSY = 2'd1,
    FR_DONE = 2'd2
  } fr_state_t;

  // One byte through a reflected CRC, least significant bit first.
  function automatic logic [31:0] crc_step_byte(input logic [31:0] c_in,
                                                input logic [7:0]  d,
                                                input logic [31:0] poly);
    logic [31:0] c;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ poly;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/afilt_seq.sv
module afilt_seq #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_valid,
  input  logic             byte_last,
  output logic             frame_start,
  output logic             frame_end,
  output logic             len_ok,
  output logic [IDX_W-1:0] byte_idx
);
  import afilt_pkg::*;

  fr_state_t        state_q;
  logic [IDX_W-1:0] idx_q;

  assign byte_idx    = (state_q == FR_BUSY) ? idx_q : '0;
  assign frame_start = byte_valid && (state_q != FR_BUSY);
  assign frame_end   = byte_valid && byte_last;
  assign len_ok      = frame_end && (byte_idx == IDX_W'(ADDR_BYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      idx_q   <= '0;
    end else if (byte_valid) begin
      state_q <= byte_last ? FR_DONE : FR_BUSY;
      if (byte_idx != IDX_W'(ADDR_BYTES))
        idx_q <= byte_idx + 1'b1;
      else
        idx_q <= byte_idx;
    end
  end

endmodule

// File: rtl/afilt_crc.sv
module afilt_crc #(
  parameter logic [31:0] POLY      = 32'hEDB88320,
  parameter int unsigned HASH_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 byte_valid,
  input  logic                 frame_start,
  input  logic [7:0]           byte_data,
  output logic [HASH_BITS-1:0] hash_now
);
  import afilt_pkg::*;

  logic [31:0] crc_q;
  logic [31:0] crc_in;
  logic [31:0] crc_next;

  assign crc_in   = frame_start ? 32'hFFFF_FFFF : crc_q;
  assign crc_next = crc_step_byte(crc_in, byte_data, POLY);
  assign hash_now = crc_next[31 -: HASH_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          crc_q <= 32'hFFFF_FFFF;
    else if (byte_valid) crc_q <= crc_next;
  end

endmodule

// File: rtl/afilt_ucast.sv
module afilt_ucast #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned IDX_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    byte_valid,
  input  logic                    frame_start,
  input  logic [7:0]              byte_data,
  input  logic [IDX_W-1:0]        byte_idx,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  output logic                    match_now,
  output logic                    mcast_now
);
  logic match_q;
  logic mcast_q;
  logic byte_eq;

  always_comb begin
    byte_eq = 1'b0;
    for (int k = 0; k < int'(ADDR_BYTES); k++) begin
      if (byte_idx == IDX_W'(k))
        byte_eq = (byte_data == station_addr[8*k +: 8]);
    end
  end

  assign match_now = (frame_start ? 1'b1 : match_q) && byte_eq;
  assign mcast_now = frame_start ? byte_data[0] : mcast_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      mcast_q <= 1'b0;
    end else if (byte_valid) begin
      match_q <= match_now;
      mcast_q <= mcast_now;
    end
  end

endmodule

// File: rtl/afilt_decide.sv
module afilt_decide #(
  parameter int unsigned HASH_BITS   = 6,
  parameter int unsigned FILT_WORD_W = 16
) (
  input  logic [HASH_BITS-1:0]      hash_idx,
  input  logic [(1<<HASH_BITS)-1:0] filt_words,
  input  logic                      is_mcast,
  input  logic                      ucast_hit,
  input  logic                      len_ok,
  input  logic                      promisc,
  output logic                      hash_hit,
  output logic                      verdict
);
  localparam int unsigned FILT_WORDS = (1 << HASH_BITS) / FILT_WORD_W;
  localparam int unsigned BSEL_W     = $clog2(FILT_WORD_W);
  localparam int unsigned WSEL_W     = HASH_BITS - BSEL_W;

  logic [FILT_WORD_W-1:0] fw [FILT_WORDS];
  logic [WSEL_W-1:0]      word_sel;
  logic [BSEL_W-1:0]      bit_sel;

  for (genvar g = 0; g < int'(FILT_WORDS); g++) begin : g_word
    assign fw[g] = filt_words[g*FILT_WORD_W +: FILT_WORD_W];
  end

  assign word_sel = hash_idx[HASH_BITS-1 -: WSEL_W];
  assign bit_sel  = hash_idx[BSEL_W-1:0];
  assign hash_hit = fw[word_sel][bit_sel];

  always_comb begin
    if (promisc)      verdict = 1'b1;
    else if (!len_ok) verdict = 1'b0;
    else if (is_mcast) verdict = hash_hit;
    else              verdict = ucast_hit;
  end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int unsigned ADDR_BYTES  = 6,
  parameter int unsigned HASH_BITS   = 6,
  parameter int unsigned FILT_WORD_W = 16,
  parameter logic [31:0] CRC_POLY    = 32'hEDB88320
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      byte_valid,
  input  logic [7:0]                byte_data,
  input  logic                      byte_last,
  input  logic [(1<<HASH_BITS)-1:0] filt_words,
  input  logic [8*ADDR_BYTES-1:0]   station_addr,
  input  logic                      promisc,
  output logic                      result_valid,
  output logic                      accept
);
  localparam int unsigned IDX_W = $clog2(ADDR_BYTES + 1) + 1;

  // Named internal events, observed by the bound checker
  logic                 frame_start;
  logic                 frame_end;
  logic                 len_ok;
  logic [IDX_W-1:0]     byte_idx;
  logic [HASH_BITS-1:0] hash_idx;
  logic                 is_mcast;
  logic                 ucast_hit;
  logic                 hash_hit;
  logic                 verdict;

  afilt_seq #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_last(byte_last),
    .frame_start(frame_start), .frame_end(frame_end), .len_ok(len_ok),
    .byte_idx(byte_idx)
  );

  afilt_crc #(.POLY(CRC_POLY), .HASH_BITS(HASH_BITS)) u_crc (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid),
    .frame_start(frame_start), .byte_data(byte_data), .hash_now(hash_idx)
  );

  afilt_ucast #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_ucast (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid),
    .frame_start(frame_start), .byte_data(byte_data), .byte_idx(byte_idx),
    .station_addr(station_addr), .match_now(ucast_hit), .mcast_now(is_mcast)
  );

  afilt_decide #(.HASH_BITS(HASH_BITS), .FILT_WORD_W(FILT_WORD_W)) u_dec (
    .hash_idx(hash_idx), .filt_words(filt_words), .is_mcast(is_mcast),
    .ucast_hit(ucast_hit), .len_ok(len_ok), .promisc(promisc),
    .hash_hit(hash_hit), .verdict(verdict)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_valid <= 1'b0;
      accept       <= 1'b0;
    end else if (frame_end) begin
      result_valid <= 1'b1;
      accept       <= verdict;
    end else if (frame_start) begin
      result_valid <= 1'b0;
      accept       <= 1'b0;
    end
  end

endmodule

// File: rtl/afilt_chk.sv
module afilt_chk (
  input logic clk,
  input logic rst_n,
  input logic promisc,
  input logic result_valid,
  input logic accept,
  input logic byte_valid,
  input logic frame_start,
  input logic frame_end,
  input logic len_ok,
  input logic is_mcast,
  input logic hash_hit,
  input logic ucast_hit
);

  a_r7_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> result_valid);

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && !byte_valid) |=> (result_valid && $stable(accept)));

  a_r8_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !frame_end) |=> (!result_valid && !accept));

  a_r6_promisc_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && promisc) |=> accept);

  a_r9_bad_length_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !len_ok && !promisc) |=> !accept);

  a_r3_group_uses_hash: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && len_ok && is_mcast && !promisc) |=> (accept == $past(hash_hit)));

  a_r5_individual_uses_match: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && len_ok && !is_mcast && !promisc) |=> (accept == $past(ucast_hit)));

  a_r1_accept_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> result_valid);

endmodule

bind rx_addr_filter afilt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .promisc(promisc), .result_valid(result_valid),
  .accept(accept), .byte_valid(byte_valid), .frame_start(frame_start),
  .frame_end(frame_end), .len_ok(len_ok), .is_mcast(is_mcast),
  .hash_hit(hash_hit), .ucast_hit(ucast_hit)
);

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        byte_last = 1'b0;
  logic [63:0] filt_words = '0;
  logic [47:0] station_addr = '0;
  logic        promisc = 1'b0;
  logic        result_valid;
  logic        accept;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  rx_addr_filter u0 (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_last(byte_last), .filt_words(filt_words), .station_addr(station_addr),
    .promisc(promisc), .result_valid(result_valid), .accept(accept)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Hash of an address, computed bit by bit as a serial shift register (R2)
  function automatic logic [5:0] ref_hash(input logic [47:0] a);
    logic [31:0] c;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int b = 0; b < 48; b++) begin
      fb = c[0] ^ a[b];
      c  = {1'b0, c[31:1]};
      if (fb) c = c ^ 32'hEDB88320;
    end
    return c[31:26];
  endfunction

  function automatic logic ref_accept(input logic [47:0] a, input int n);
    if (promisc) return 1'b1;
    if (n != 6) return 1'b0;
    if (a[0]) return filt_words[ref_hash(a)];
    return a == station_addr;
  endfunction

  task automatic send(input logic [47:0] a, input int n, input int gap,
                      input string req);
    logic exp;
    exp = ref_accept(a, n);
    for (int i = 0; i < n; i++) begin
      byte_valid = 1'b1;
      byte_data  = (i < 6) ? a[8*i +: 8] : 8'hA5;
      byte_last  = (i == n - 1);
      @(posedge clk);
      @(negedge clk);
      if (i == 0 && n > 1) check("R8 clear on new frame", result_valid, 1'b0);
      if (i < n - 1 && gap > 0) begin
        byte_valid = 1'b0;
        repeat (gap) @(negedge clk);
      end
    end
    byte_valid = 1'b0;
    byte_last  = 1'b0;
    check("R7 valid after last", result_valid, 1'b1);
    check(req, accept, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [47:0] a;
    logic [5:0]  h;
    logic        keep;
    repeat (3) @(negedge clk);
    check("R1 result_valid reset", result_valid, 1'b0);
    check("R1 accept reset", accept, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3: each group address against one-hot and one-cold tables
    for (int i = 0; i < 64; i++) begin
      a = {8'(i * 37 + 3), 8'(i), 8'h00, 8'h5E, 8'h00, 8'h01};
      h = ref_hash(a);
      filt_words = 64'd1 << h;
      send(a, 6, 0, "R2 R3 hash bit set");
      filt_words = ~(64'd1 << h);
      send(a, 6, 0, "R3 hash bit clear");
    end

    // R4: full table keeps every group address, broadcast included
    filt_words = '1;
    send(48'hFFFF_FFFF_FFFF, 6, 0, "R4 broadcast");
    for (int i = 0; i < 16; i++)
      send({8'(i * 91), 8'(i * 13), 8'h33, 8'h22, 8'h11, 8'(2 * i + 1)}, 6, 0,
           "R4 all multicast");
    filt_words = '0;
    send(48'hFFFF_FFFF_FFFF, 6, 0, "R3 broadcast empty table");

    // R5: exact match and every single-bit difference
    station_addr = 48'h6655_4433_2200;
    send(station_addr, 6, 0, "R5 exact match");
    filt_words = '1;
    send(station_addr, 6, 0, "R5 exact match full table");
    for (int b = 0; b < 48; b++) begin
      a = station_addr ^ (48'd1 << b);
      send(a, 6, 0, "R5 single bit differs");
    end
    filt_words = '0;
    send(station_addr ^ 48'd1, 6, 0, "R5 bit0 flip makes group");

    // R9: wrong lengths
    send(station_addr, 5, 0, "R9 five bytes");
    send(station_addr, 7, 0, "R9 seven bytes");
    filt_words = '1;
    send(48'h0000_0000_0001, 5, 0, "R9 group five bytes");
    send(48'h0000_0000_0001, 1, 0, "R9 one byte");

    // R6: promiscuous, any address and length
    promisc = 1'b1;
    filt_words = '0;
    send(48'h1234_5678_9AB0, 6, 0, "R6 promisc unicast");
    send(48'h1234_5678_9AB1, 6, 0, "R6 promisc group");
    send(48'h1234_5678_9AB0, 1, 0, "R6 promisc one byte");
    send(48'h1234_5678_9AB0, 7, 0, "R6 promisc seven bytes");
    promisc = 1'b0;

    // R10: idle gaps between bytes
    send(station_addr, 6, 2, "R10 gap match");
    send(station_addr ^ 48'h0100_0000_0000, 6, 3, "R10 gap mismatch");
    a = {8'h77, 8'h66, 8'h00, 8'h5E, 8'h00, 8'h01};
    filt_words = 64'd1 << ref_hash(a);
    send(a, 6, 1, "R10 gap group");

    // R7: verdict holds while inputs move
    send(station_addr, 6, 0, "R7 before hold");
    keep = accept;
    promisc = 1'b1;
    filt_words = '0;
    station_addr = 48'h0;
    repeat (5) @(negedge clk);
    check("R7 hold valid", result_valid, 1'b1);
    check("R7 hold accept", accept, keep);
    promisc = 1'b0;
    station_addr = 48'h6655_4433_2200;
    repeat (5) @(negedge clk);
    send(48'h0000_0000_0010, 6, 0, "R7 reject then hold");
    promisc = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 hold reject", accept, 1'b0);
    promisc = 1'b0;

    // R8: back-to-back frames with no idle cycle
    send(station_addr, 6, 0, "R8 first of pair");
    send(48'h0000_0000_0010, 6, 0, "R8 second of pair");
    send(station_addr, 6, 0, "R8 third of pair");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule